// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This is a purely combinational integer arithmetic and logic unit for the execute stage of a load/store RISC core. It takes two 32-bit operands, a 5-bit constant shift amount and a 5-bit operation code. It returns a 32-bit result and a flag that requests an overflow exception. The unit covers:

- addition and subtraction, in trapping and wrapping forms;
- the four bitwise operations;
- signed and unsigned set-on-less-than;
- left, logical right and arithmetic right shifts, with a constant or a register-supplied amount;
- load-upper-immediate.

The unit does not extend immediates. An add-immediate is issued as the trapping or wrapping add, with the already extended immediate on `b_i`. The result is always driven. When the flag is high, the consumer must suppress the register write and take the exception.

Top module: `int_alu`

## Requirements
- R1: With op 0 (trapping add), the result is a+b modulo 2^32. ovf_o is 1 exactly when a and b have the same sign bit and the sum's sign bit differs from it.
- R2: With op 2 (trapping subtract), the result is a-b modulo 2^32. ovf_o is 1 exactly when a and b have different sign bits and the result's sign bit differs from a's.
- R3: Op 1 (wrapping add) and op 3 (wrapping subtract) give the same results as ops 0 and 2 for any operands, and ovf_o is always 0 for them.
- R4: Ops 4, 5, 6 and 7 give the bitwise and, or, xor and nor of a and b respectively, with ovf_o 0.
- R5: Op 8 gives 1 when a<b as two's-complement numbers, otherwise 0. Op 9 does the same as unsigned numbers. In both cases bits 31:1 of the result are 0.
- R6: Ops 10, 11 and 12 shift b left logically, right logically and right arithmetically by shamt_i. An arithmetic right shift fills the vacated bits with b[31].
- R7: Ops 13, 14 and 15 perform the same three shifts of b by the amount a[4:0]. Bits 31:5 of a and shamt_i have no effect.
- R8: Op 16 places b[15:0] in result bits 31:16 and zeros in bits 15:0. Operand a has no effect.
- R9: While ovf_o is 1, the result still carries the wrapped sum or difference.
- R10: Op codes 17 to 31 give result 0 and ovf_o 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand; also the amount source for variable shifts |
| b_i | input | 32 | Second operand (register or pre-extended immediate); the value being shifted |
| shamt_i | input | 5 | Constant shift amount |
| op_i | input | 5 | Operation code |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Request for a signed overflow exception |

## Verification
The hardest condition to bring about is an overflow right at the boundary of the signed range. Uniform random operands produce overflow often, but they almost never land on the largest positive value plus one, or the most negative value minus one. For that reason the stimulus adds directed pairs at those edges. It applies each pair under both the trapping and the wrapping codes, so the same sum is seen with and without the flag.

A second hard case is a register shift amount whose upper bits are set. Random values for `a_i` cover it. A directed case with a non-zero `shamt_i` shows that the constant amount is ignored.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic [$clog2(W)-1:0] shamt_i,
  input  logic [4:0]           op_i,
  output logic [W-1:0]         result_o,
  output logic                 ovf_o
);
  localparam int SW = $clog2(W);
  localparam int HW = W / 2;

  localparam logic [4:0] OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3;
  localparam logic [4:0] OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_NOR  = 5'd7;
  localparam logic [4:0] OP_SLT  = 5'd8,  OP_SLTU = 5'd9;
  localparam logic [4:0] OP_SLL  = 5'd10, OP_SRL  = 5'd11, OP_SRA  = 5'd12;
  localparam logic [4:0] OP_SLLV = 5'd13, OP_SRLV = 5'd14, OP_SRAV = 5'd15;
  localparam logic [4:0] OP_LUI  = 5'd16;

  logic          is_sub;
  logic [W-1:0]  b_eff, sum;
  logic          carry, sgn_ovf, lt_s, lt_u;
  logic [SW-1:0] amt;

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SUBU) || (op_i == OP_SLT) || (op_i == OP_SLTU);
  assign b_eff  = is_sub ? ~b_i : b_i;
  assign {carry, sum} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};

  assign sgn_ovf = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);
  assign lt_s    = sum[W-1] ^ sgn_ovf;
  assign lt_u    = ~carry;

  assign amt = (op_i == OP_SLLV || op_i == OP_SRLV || op_i == OP_SRAV) ? a_i[SW-1:0] : shamt_i;

  always_comb begin
    result_o = '0;
    unique case (op_i)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
      OP_AND:                  result_o = a_i & b_i;
      OP_OR:                   result_o = a_i | b_i;
      OP_XOR:                  result_o = a_i ^ b_i;
      OP_NOR:                  result_o = ~(a_i | b_i);
      OP_SLT:                  result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:                 result_o = {{(W-1){1'b0}}, lt_u};
      OP_SLL, OP_SLLV:         result_o = b_i << amt;
      OP_SRL, OP_SRLV:         result_o = b_i >> amt;
      OP_SRA, OP_SRAV:         result_o = W'($signed(b_i) >>> amt);
      OP_LUI:                  result_o = {b_i[HW-1:0], {(W-HW){1'b0}}};
      default:                 result_o = '0;
    endcase
  end

  assign ovf_o = sgn_ovf && (op_i == OP_ADD || op_i == OP_SUB);
endmodule

module int_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [4:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         ovf_o
);
  localparam int HW = W / 2;

  always_comb begin
    if (op_i == 5'd0)
      assert_add_ovf_R1: assert (ovf_o == ((a_i[W-1] == b_i[W-1]) && (result_o[W-1] != a_i[W-1])));
    if (op_i == 5'd2)
      assert_sub_ovf_R2: assert (ovf_o == ((a_i[W-1] != b_i[W-1]) && (result_o[W-1] != a_i[W-1])));
    if (op_i != 5'd0 && op_i != 5'd2)
      assert_no_overflow_R3: assert (!ovf_o);
    if (op_i == 5'd8 || op_i == 5'd9)
      assert_slt_bit_R5: assert (result_o[W-1:1] == '0);
    if (op_i == 5'd12 || op_i == 5'd15)
      assert_sra_sign_R6: assert (result_o[W-1] == b_i[W-1]);
    if (op_i == 5'd16)
      assert_lui_low_R8: assert (result_o[HW-1:0] == '0 && result_o[W-1:HW] == b_i[HW-1:0]);
    if (op_i > 5'd16)
      assert_unused_zero_R10: assert (result_o == '0);
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .result_o(result_o), .ovf_o(ovf_o)
);

// File: tb/sim_int_alu.sv
module sim_int_alu;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] a, b, res;
  logic [4:0]  sh, op;
  logic        ovf;
  int          total = 0, fails = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  int_alu u0 (.a_i(a), .b_i(b), .shamt_i(sh), .op_i(op), .result_o(res), .ovf_o(ovf));

  function automatic logic [32:0] model(input logic [31:0] x, y, input logic [4:0] s, o);
    logic signed [32:0] wide;
    logic [31:0] r;
    logic v;
    r = '0; v = 1'b0;
    case (o)
      0, 1: begin wide = $signed({x[31], x}) + $signed({y[31], y}); r = wide[31:0]; v = (o == 0) && (wide > 33'sd2147483647 || wide < -33'sd2147483648); end
      2, 3: begin wide = $signed({x[31], x}) - $signed({y[31], y}); r = wide[31:0]; v = (o == 2) && (wide > 33'sd2147483647 || wide < -33'sd2147483648); end
      4: r = x & y;
      5: r = x | y;
      6: r = x ^ y;
      7: r = ~(x | y);
      8: r = {31'd0, $signed(x) < $signed(y)};
      9: r = {31'd0, x < y};
      10: for (int i = 0; i < 32; i++) r[i] = (i >= s) ? y[i-s] : 1'b0;
      11: for (int i = 0; i < 32; i++) r[i] = (i + s < 32) ? y[i+s] : 1'b0;
      12: for (int i = 0; i < 32; i++) r[i] = (i + s < 32) ? y[i+s] : y[31];
      13: r = model(x, y, x[4:0], 5'd10)[31:0];
      14: r = model(x, y, x[4:0], 5'd11)[31:0];
      15: r = model(x, y, x[4:0], 5'd12)[31:0];
      16: r = {y[15:0], 16'h0};
      default: r = '0;
    endcase
    return {v, r};
  endfunction

  function automatic string tag(input logic [4:0] o);
    if (o <= 5'd2 && o != 5'd1) return (o == 0) ? "R1" : "R2";
    if (o <= 5'd3) return "R3";
    if (o <= 5'd7) return "R4";
    if (o <= 5'd9) return "R5";
    if (o <= 5'd12) return "R6";
    if (o <= 5'd15) return "R7";
    if (o == 5'd16) return "R8";
    return "R10";
  endfunction

  task automatic apply(input logic [31:0] x, y, input logic [4:0] s, o, input string req);
    logic [32:0] exp;
    @(negedge clk);
    a = x; b = y; sh = s; op = o;
    exp = model(x, y, s, o);
    #1;
    total++;
    if ({ovf, res} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got ovf=%b res=%h, expected ovf=%b res=%h",
               req, o, x, y, s, ovf, res, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1234abcd;
    void'($urandom(seed));
    a = '0; b = '0; sh = '0; op = '0;
    // R1 / R9: overflow at the edges of the signed range, result still driven
    apply(32'h7fffffff, 32'h1,        0, 0, "R1 R9");
    apply(32'h80000000, 32'hffffffff, 0, 0, "R1 R9");
    apply(32'h7fffffff, 32'h0,        0, 0, "R1");
    // R2: subtract overflow both directions
    apply(32'h80000000, 32'h1,        0, 2, "R2 R9");
    apply(32'h7fffffff, 32'hffffffff, 0, 2, "R2");
    apply(32'h0,        32'h80000000, 0, 2, "R2");
    // R3: same operands through the wrapping forms
    apply(32'h7fffffff, 32'h1,        0, 1, "R3");
    apply(32'h80000000, 32'h1,        0, 3, "R3");
    // R5: signed versus unsigned ordering differs for negatives
    apply(32'hffffffff, 32'h1,        0, 8, "R5");
    apply(32'hffffffff, 32'h1,        0, 9, "R5");
    apply(32'h5,        32'h5,        0, 8, "R5");
    // R6: arithmetic fill and full-width amount
    apply(32'h0,        32'h80000000, 31, 12, "R6");
    apply(32'h0,        32'h80000001, 31, 11, "R6");
    // R7: upper amount bits and constant amount ignored
    apply(32'hffffffe4, 32'h80000000, 7, 15, "R7");
    apply(32'h00000020, 32'h12345678, 9, 13, "R7");
    // R8: a has no effect
    apply(32'hdeadbeef, 32'hffff1234, 3, 16, "R8");
    // R10: unused codes
    apply(32'hffffffff, 32'hffffffff, 5, 17, "R10");
    apply(32'h7fffffff, 32'h1,        5, 31, "R10");
    // R4 and all others: random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] o;
      o = 5'($urandom_range(0, 31));
      apply($urandom, $urandom, 5'($urandom), o, tag(o));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule